// File: doc/BRIEF.md
# Poison-Tagged Speculative Register File

This block is an integer register file for deferred-fault software speculation. Each entry holds a data word and a separate one-bit poison tag. A speculative load that cannot deliver a value does not trap at load time. It writes its destination with the tag set. Arithmetic results built from a poisoned source inherit the tag, so the poison flows through dependent code without raising any exception.

Only a non-speculative store turns poison into an error. The store-check port looks up the register a store wants to use. If that register is poisoned, the block raises a one-cycle fault carrying the register index instead of handing out the data.

The file has two combinational read ports, one write port and one store-check port. Register 0 is hardwired to zero. The register count defaults to 128 and can be reduced for test.

Top module: `poison_regfile`

## Requirements
- R1: After reset every register reads zero with a clear tag, and the fault output is low.
- R2: A write of kind 2'b00 (plain result) stores the data and clears the tag of the destination. The new value is visible on both read ports from the next cycle on.
- R3: A write of kind 2'b01 (failed speculative load) stores the data and sets the destination tag.
- R4: A write of kind 2'b10 (ALU result) stores the data. Its tag is the OR of the tags of the two source indices, as those tags stood before the write. No fault is raised by this write.
- R5: A write of kind 2'b11 changes no register.
- R6: Register 0 always reads zero with a clear tag. Writes to it are ignored for both data and tag. A store check on it never faults.
- R7: A read that names the register being written in the same cycle returns the incoming data and the incoming tag.
- R8: A valid store check on a poisoned register raises the fault for exactly one cycle, the cycle after the check. In that cycle it reports the register index, and the store data output is zero.
- R9: A valid store check on a clean register raises no fault. The register's data appears on the store data output in the next cycle.
- R10: With store-valid low, no fault is raised, whatever index is presented.
- R11: A store check sees a write to the same register in the same cycle. The fault decision uses the incoming tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | ADDR_W | Read port A index |
| rd_a_data | output | DATA_W | Read port A data |
| rd_a_poison | output | 1 | Read port A poison tag |
| rd_b_idx | input | ADDR_W | Read port B index |
| rd_b_data | output | DATA_W | Read port B data |
| rd_b_poison | output | 1 | Read port B poison tag |
| wr_en | input | 1 | Write enable |
| wr_kind | input | 2 | Write kind: 00 plain, 01 failed spec load, 10 ALU, 11 none |
| wr_idx | input | ADDR_W | Write destination index |
| wr_data | input | DATA_W | Write data |
| wr_src0_idx | input | ADDR_W | First ALU source index, for tag propagation |
| wr_src1_idx | input | ADDR_W | Second ALU source index, for tag propagation |
| st_valid | input | 1 | Store check request valid |
| st_idx | input | ADDR_W | Register used by the store |
| fault | output | 1 | One-cycle poisoned-store fault |
| fault_idx | output | ADDR_W | Index of the offending register |
| st_data | output | DATA_W | Store data for a clean check, else zero |

## Verification
Every write kind goes to the same registers in turn. This separates clearing the tag, setting it, propagating it and ignoring the write. ALU writes are driven with both a poisoned/clean source pair and a clean/clean pair, which shows that the tag is an OR of the sources and not a copy of one of them. Writes and reads, and writes and store checks, are driven to the same index in the same cycle to expose the bypass path. Store checks are aimed at poisoned, clean and zero registers, both with store-valid high and with it low. This separates a correct fault from a missing fault and from a spurious one.

// File: rtl/prf_pkg.sv
package prf_pkg;
    typedef enum logic [1:0] {
        WK_PLAIN     = 2'b00,
        WK_SPEC_MISS = 2'b01,
        WK_ALU       = 2'b10,
        WK_NONE      = 2'b11
    } wr_kind_e;
endpackage

// File: rtl/prf_write_ctrl.sv
module prf_write_ctrl #(
    parameter int ADDR_W = 7
) (
    input  logic              wr_en,
    input  logic [1:0]        wr_kind,
    input  logic [ADDR_W-1:0] wr_idx,
    input  logic              src0_tag,
    input  logic              src1_tag,
    output logic              commit,
    output logic              commit_tag
);
    import prf_pkg::*;

    always_comb begin
        commit     = wr_en && (wr_idx != '0) && (wr_kind != WK_NONE);
        commit_tag = 1'b0;
        unique case (wr_kind)
            WK_PLAIN:     commit_tag = 1'b0;
            WK_SPEC_MISS: commit_tag = 1'b1;
            WK_ALU:       commit_tag = src0_tag | src1_tag;
            default:      commit_tag = 1'b0;
        endcase
    end
endmodule

// File: rtl/prf_storage.sv
module prf_storage #(
    parameter int NUM_REGS = 128,
    parameter int DATA_W   = 64,
    parameter int ADDR_W   = 7
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             commit,
    input  logic                             commit_tag,
    input  logic [ADDR_W-1:0]                wr_idx,
    input  logic [DATA_W-1:0]                wr_data,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  data_q,
    output logic [NUM_REGS-1:0]              tag_q
);
    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] data;
        logic [NUM_REGS-1:0]             tag;
    } file_t;

    file_t file_d, file_q;

    always_comb begin
        file_d = file_q;
        if (commit) begin
            file_d.data[wr_idx] = wr_data;
            file_d.tag[wr_idx]  = commit_tag;
        end
        file_d.data[0] = '0;
        file_d.tag[0]  = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) file_q <= '0;
        else        file_q <= file_d;
    end

    assign data_q = file_q.data;
    assign tag_q  = file_q.tag;
endmodule

// File: rtl/prf_lookup.sv
module prf_lookup #(
    parameter int NUM_REGS = 128,
    parameter int DATA_W   = 64,
    parameter int ADDR_W   = 7
) (
    input  logic [ADDR_W-1:0]                idx,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]  data_q,
    input  logic [NUM_REGS-1:0]              tag_q,
    input  logic                             commit,
    input  logic                             commit_tag,
    input  logic [ADDR_W-1:0]                wr_idx,
    input  logic [DATA_W-1:0]                wr_data,
    output logic [DATA_W-1:0]                out_data,
    output logic                             out_tag
);
    always_comb begin
        if (idx == '0) begin
            out_data = '0;
            out_tag  = 1'b0;
        end else if (commit && (wr_idx == idx)) begin
            out_data = wr_data;
            out_tag  = commit_tag;
        end else begin
            out_data = data_q[idx];
            out_tag  = tag_q[idx];
        end
    end
endmodule

// File: rtl/prf_store_check.sv
module prf_store_check #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_idx,
    input  logic [DATA_W-1:0] look_data,
    input  logic              look_tag,
    output logic              fault,
    output logic [ADDR_W-1:0] fault_idx,
    output logic [DATA_W-1:0] st_data
);
    typedef struct packed {
        logic              fault;
        logic [ADDR_W-1:0] idx;
        logic [DATA_W-1:0] data;
    } chk_t;

    chk_t chk_d, chk_q;

    always_comb begin
        chk_d = '0;
        if (st_valid) begin
            if (look_tag) begin
                chk_d.fault = 1'b1;
                chk_d.idx   = st_idx;
            end else begin
                chk_d.data  = look_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chk_q <= '0;
        else        chk_q <= chk_d;
    end

    assign fault     = chk_q.fault;
    assign fault_idx = chk_q.idx;
    assign st_data   = chk_q.data;
endmodule

// File: rtl/poison_regfile.sv
module poison_regfile #(
    parameter int NUM_REGS = 128,
    parameter int DATA_W   = 64,
    parameter int ADDR_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    output logic              rd_a_poison,
    input  logic [ADDR_W-1:0] rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    output logic              rd_b_poison,
    input  logic              wr_en,
    input  logic [1:0]        wr_kind,
    input  logic [ADDR_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] wr_src0_idx,
    input  logic [ADDR_W-1:0] wr_src1_idx,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_idx,
    output logic              fault,
    output logic [ADDR_W-1:0] fault_idx,
    output logic [DATA_W-1:0] st_data
);
    localparam int NUM_LOOK = 3;

    logic [NUM_REGS-1:0][DATA_W-1:0] data_q;
    logic [NUM_REGS-1:0]             tag_q;
    logic                            commit;
    logic                            commit_tag;
    logic                            src0_tag;
    logic                            src1_tag;

    logic [NUM_LOOK-1:0][ADDR_W-1:0] look_idx;
    logic [NUM_LOOK-1:0][DATA_W-1:0] look_data;
    logic [NUM_LOOK-1:0]             look_tag;

    // ALU sources see the tags held before this cycle's write
    assign src0_tag = (wr_src0_idx == '0) ? 1'b0 : tag_q[wr_src0_idx];
    assign src1_tag = (wr_src1_idx == '0) ? 1'b0 : tag_q[wr_src1_idx];

    prf_write_ctrl #(.ADDR_W(ADDR_W)) u_wctl (
        .wr_en      (wr_en),
        .wr_kind    (wr_kind),
        .wr_idx     (wr_idx),
        .src0_tag   (src0_tag),
        .src1_tag   (src1_tag),
        .commit     (commit),
        .commit_tag (commit_tag)
    );

    prf_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .commit_tag (commit_tag),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .data_q     (data_q),
        .tag_q      (tag_q)
    );

    assign look_idx[0] = rd_a_idx;
    assign look_idx[1] = rd_b_idx;
    assign look_idx[2] = st_idx;

    for (genvar g = 0; g < NUM_LOOK; g++) begin : g_look
        prf_lookup #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_look (
            .idx        (look_idx[g]),
            .data_q     (data_q),
            .tag_q      (tag_q),
            .commit     (commit),
            .commit_tag (commit_tag),
            .wr_idx     (wr_idx),
            .wr_data    (wr_data),
            .out_data   (look_data[g]),
            .out_tag    (look_tag[g])
        );
    end

    assign rd_a_data   = look_data[0];
    assign rd_a_poison = look_tag[0];
    assign rd_b_data   = look_data[1];
    assign rd_b_poison = look_tag[1];

    prf_store_check #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
        .clk       (clk),
        .rst_n     (rst_n),
        .st_valid  (st_valid),
        .st_idx    (st_idx),
        .look_data (look_data[2]),
        .look_tag  (look_tag[2]),
        .fault     (fault),
        .fault_idx (fault_idx),
        .st_data   (st_data)
    );
endmodule

// File: rtl/prf_checker.sv
module prf_checker #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] rd_a_idx,
    input logic [DATA_W-1:0] rd_a_data,
    input logic              rd_a_poison,
    input logic              wr_en,
    input logic [1:0]        wr_kind,
    input logic [ADDR_W-1:0] wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic              st_valid,
    input logic [ADDR_W-1:0] st_idx,
    input logic              fault,
    input logic [ADDR_W-1:0] fault_idx
);
    import prf_pkg::*;

    AST_ZERO_REG_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == '0) |-> (rd_a_data == '0 && !rd_a_poison)); // R6

    AST_PLAIN_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == WK_PLAIN && wr_idx == rd_a_idx && wr_idx != '0)
        |-> (rd_a_data == wr_data && !rd_a_poison)); // R7

    AST_SPEC_TAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en && wr_kind == WK_SPEC_MISS && wr_idx != '0)
         && rd_a_idx == $past(wr_idx)
         && !(wr_en && wr_idx == rd_a_idx && wr_kind != WK_NONE))
        |-> rd_a_poison); // R3

    AST_FAULT_NEEDS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> ($past(st_valid) && $past(st_idx) == fault_idx)); // R8

    AST_NO_FAULT_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (fault_idx != '0)); // R8

    AST_ZERO_NEVER_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_idx == '0) |=> !fault); // R6
endmodule

bind poison_regfile prf_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_prf_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_a_idx    (rd_a_idx),
    .rd_a_data   (rd_a_data),
    .rd_a_poison (rd_a_poison),
    .wr_en       (wr_en),
    .wr_kind     (wr_kind),
    .wr_idx      (wr_idx),
    .wr_data     (wr_data),
    .st_valid    (st_valid),
    .st_idx      (st_idx),
    .fault       (fault),
    .fault_idx   (fault_idx)
);

// File: tb/poison_regfile_test.sv
module poison_regfile_test;
    localparam int NR = 16;
    localparam int DW = 64;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] rd_a_idx = '0, rd_b_idx = '0;
    logic [DW-1:0] rd_a_data, rd_b_data;
    logic          rd_a_poison, rd_b_poison;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_kind = 2'b00;
    logic [AW-1:0] wr_idx = '0, wr_src0_idx = '0, wr_src1_idx = '0;
    logic [DW-1:0] wr_data = '0;
    logic          st_valid = 1'b0;
    logic [AW-1:0] st_idx = '0;
    logic          fault;
    logic [AW-1:0] fault_idx;
    logic [DW-1:0] st_data;

    always #2.5 clk = ~clk;

    poison_regfile #(.NUM_REGS(NR), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data), .rd_a_poison(rd_a_poison),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .rd_b_poison(rd_b_poison),
        .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx), .wr_data(wr_data),
        .wr_src0_idx(wr_src0_idx), .wr_src1_idx(wr_src1_idx),
        .st_valid(st_valid), .st_idx(st_idx),
        .fault(fault), .fault_idx(fault_idx), .st_data(st_data)
    );

    typedef struct {
        int            due;
        int            port;   // 0 read A, 1 read B, 2 store check
        logic [DW-1:0] data;
        logic          tag;
        logic          flt;
        logic [AW-1:0] fidx;
        string         req;
    } item_t;

    item_t         sb[$];
    int            cyc = 0;
    int            compared = 0;
    int            mismatched = 0;
    bit            done = 1'b0;
    logic [DW-1:0] m_data [NR];
    logic          m_tag  [NR];

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compares due items at the falling edge
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            item_t it;
            it = sb.pop_front();
            compared++;
            if (it.due < cyc) begin
                mismatched++;
                $display("FAIL %s: item missed its cycle (due %0d, now %0d)", it.req, it.due, cyc);
            end else if (it.port == 0 && (rd_a_data !== it.data || rd_a_poison !== it.tag)) begin
                mismatched++;
                $display("FAIL %s: port A got %h/%b expected %h/%b", it.req, rd_a_data, rd_a_poison, it.data, it.tag);
            end else if (it.port == 1 && (rd_b_data !== it.data || rd_b_poison !== it.tag)) begin
                mismatched++;
                $display("FAIL %s: port B got %h/%b expected %h/%b", it.req, rd_b_data, rd_b_poison, it.data, it.tag);
            end else if (it.port == 2 && (fault !== it.flt || st_data !== it.data
                         || (it.flt && fault_idx !== it.fidx))) begin
                mismatched++;
                $display("FAIL %s: store got fault=%b idx=%0d data=%h expected fault=%b idx=%0d data=%h",
                         it.req, fault, fault_idx, st_data, it.flt, it.fidx, it.data);
            end
        end
    end

    function automatic logic new_tag(input logic [1:0] k, input logic [AW-1:0] s0, input logic [AW-1:0] s1);
        if (k == 2'b01) return 1'b1;
        if (k == 2'b10) return m_tag[s0] | m_tag[s1];
        return 1'b0;
    endfunction

    // drive one cycle and push the expected results
    task automatic step(input logic we, input logic [1:0] k, input logic [AW-1:0] wi,
                        input logic [DW-1:0] wd, input logic [AW-1:0] s0, input logic [AW-1:0] s1,
                        input logic [AW-1:0] ra, input logic [AW-1:0] rb,
                        input logic sv, input logic [AW-1:0] si, input string req);
        item_t it;
        logic  hit;
        logic  nt;
        @(posedge clk);
        #1;
        wr_en = we; wr_kind = k; wr_idx = wi; wr_data = wd;
        wr_src0_idx = s0; wr_src1_idx = s1;
        rd_a_idx = ra; rd_b_idx = rb; st_valid = sv; st_idx = si;
        hit = we && wi != 0 && k != 2'b11;
        nt  = new_tag(k, s0, s1);
        for (int p = 0; p < 3; p++) begin
            logic [AW-1:0] ix;
            ix = (p == 0) ? ra : (p == 1) ? rb : si;
            it.due = (p == 2) ? cyc + 1 : cyc;
            it.port = p; it.req = req; it.fidx = si;
            if (ix == 0) begin
                it.data = '0; it.tag = 1'b0;
            end else if (hit && wi == ix) begin
                it.data = wd; it.tag = nt;
            end else begin
                it.data = m_data[ix]; it.tag = m_tag[ix];
            end
            if (p == 2) begin
                it.flt  = sv && it.tag;
                it.data = (sv && !it.tag) ? it.data : '0;
            end
            sb.push_back(it);
        end
        if (hit) begin
            m_data[wi] = wd;
            m_tag[wi]  = nt;
        end
    endtask

    initial begin
        for (int i = 0; i < NR; i++) begin
            m_data[i] = '0;
            m_tag[i]  = 1'b0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state on reads and store path
        step(0, 2'b00, 0, 0, 0, 0, 5, 15, 1, 9, "R1");
        // R2: plain write, visible next cycle on both ports
        step(1, 2'b00, 3, 64'hA5A5_0000_1234_5678, 0, 0, 1, 2, 0, 0, "R2");
        step(0, 2'b00, 0, 0, 0, 0, 3, 3, 0, 0, "R2");
        // R3: failed speculative load sets the tag
        step(1, 2'b01, 4, 64'hDEAD_BEEF, 0, 0, 1, 2, 0, 0, "R3");
        step(0, 2'b00, 0, 0, 0, 0, 4, 3, 0, 0, "R3");
        // R4: ALU propagation, poisoned and clean source pairs
        step(1, 2'b10, 5, 64'h55, 3, 4, 2, 1, 0, 0, "R4");
        step(1, 2'b10, 6, 64'h66, 3, 3, 5, 4, 0, 0, "R4");
        step(1, 2'b10, 4, 64'h44, 3, 4, 6, 5, 0, 0, "R4");
        step(0, 2'b00, 0, 0, 0, 0, 4, 6, 0, 0, "R4");
        // R5: kind 11 leaves the register unchanged
        step(1, 2'b11, 3, 64'hFFFF_FFFF, 0, 0, 3, 2, 0, 0, "R5");
        step(0, 2'b00, 0, 0, 0, 0, 3, 3, 0, 0, "R5");
        // R6: register 0 is hardwired; writes and store check ignored
        step(1, 2'b01, 0, 64'h1234, 0, 0, 0, 0, 1, 0, "R6");
        step(1, 2'b00, 0, 64'h9999, 0, 0, 0, 0, 0, 0, "R6");
        step(0, 2'b00, 0, 0, 0, 0, 0, 0, 1, 0, "R6");
        // R7: same-cycle bypass of data and tag
        step(1, 2'b00, 7, 64'h7777_0000, 0, 0, 7, 1, 0, 0, "R7");
        step(1, 2'b01, 7, 64'h7070, 0, 0, 1, 7, 0, 0, "R7");
        // R8: poisoned store faults for one cycle
        step(0, 2'b00, 0, 0, 0, 0, 1, 2, 1, 4, "R8");
        step(0, 2'b00, 0, 0, 0, 0, 1, 2, 0, 0, "R8");
        step(0, 2'b00, 0, 0, 0, 0, 1, 2, 1, 7, "R8");
        step(0, 2'b00, 0, 0, 0, 0, 1, 2, 1, 5, "R8");
        // R9: clean store returns data
        step(0, 2'b00, 0, 0, 0, 0, 1, 2, 1, 3, "R9");
        step(0, 2'b00, 0, 0, 0, 0, 1, 2, 1, 6, "R9");
        // R10: store-valid low never faults
        step(0, 2'b00, 0, 0, 0, 0, 1, 2, 0, 4, "R10");
        step(0, 2'b00, 0, 0, 0, 0, 1, 2, 0, 7, "R10");
        // R11: store check sees same-cycle write (poisoning then clearing)
        step(1, 2'b01, 8, 64'h88, 0, 0, 8, 1, 1, 8, "R11");
        step(1, 2'b00, 4, 64'h4040, 0, 0, 1, 4, 1, 4, "R11");
        // R2: tag cleared by a plain write to a poisoned register
        step(0, 2'b00, 0, 0, 0, 0, 4, 8, 1, 4, "R2");
        // R1: reset again returns everything to zero
        @(posedge clk);
        #1 rst_n = 1'b0;
        for (int i = 0; i < NR; i++) begin
            m_data[i] = '0;
            m_tag[i]  = 1'b0;
        end
        wr_en = 1'b0; st_valid = 1'b0;
        @(posedge clk);
        #1 rst_n = 1'b1;
        step(0, 2'b00, 0, 0, 0, 0, 4, 3, 1, 8, "R1");
        step(0, 2'b00, 0, 0, 0, 0, 7, 8, 0, 0, "R1");
        repeat (3) @(posedge clk);
        if (sb.size() != 0) begin
            mismatched++;
            $display("FAIL drain: %0d items never compared, got %0d expected 0", sb.size(), 0);
        end
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            mismatched++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule